// File: doc/BRIEF.md
# State-of-Charge Step Charge Controller

This controller picks one of five charge-current steps from the battery state of charge that a host reports. The host programs four percentage thresholds and five signed current offsets through a small register write/read port. It then reports the charge level by writing it into a level register and committing it with a separate strobe write. The step index is the number of thresholds that the committed level has reached. The block drives that index and the matching signed offset to the current regulator.

The host must keep the level fresh. A request timer runs on a slow time-base tick. When it expires, the block pulses an update request and starts a failure timer. If the host commits a level before the failure timer expires, both timers restart. If it does not, a failure pulse is raised. A mode bit then chooses between two actions: jump to the final step, or hold the current step. A step-change pulse marks every change of the index. When the enable bit is clear, the block is idle.

Top module: `step_charge_ctrl`

## Requirements
- R1: After reset the step index, offset output and all three pulses are 0, the mode register is 0, both timeout selects are 0, and every threshold register reads back 100.
- R2: The host writes the level register (address 0xC) with the percentage shifted left by one. Writing 1 in bit 0 of address 0xD commits it. The step index is the count of thresholds (addresses 0x3 to 0x6) that are less than or equal to the committed level. It is visible after the second rising edge following the commit write.
- R3: The offset output is the signed two's-complement offset register of the current step (address 0x7 plus step index). It is updated together with the step index.
- R4: The step-change pulse is high for exactly one cycle whenever the step index changes, and stays low when a commit leaves the index unchanged.
- R5: While enabled, the update-request pulse fires on the limit-th tick after the last commit. The limit is the request select (address 0x1, 0/1/2/3 = 5/10/20/40 s) times TICKS_PER_SEC.
- R6: The request arms the failure timer. The failure pulse fires on the limit-th tick after the request pulse. That limit is the failure select (address 0x2, 0/1/2/3 = 10/30/60/120 s) times TICKS_PER_SEC. The request timer then restarts.
- R7: On a failure with mode bit 3 set, the step index goes to 4 and stays there until the next commit. With bit 3 clear, the step index is held.
- R8: A commit in the same cycle that the request timer expires takes priority. No request pulse is raised, and the request timer restarts from zero.
- R9: With mode bit 0 (enable) clear, the step index and offset output are 0 and neither timer pulse fires.
- R10: The read data is registered one cycle after the read address. Address 0xE returns the step index in bits 5:3. Configuration registers read back at their write addresses.
- R11: The request pulse and the failure pulse are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick, one per 1/TICKS_PER_SEC second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Registered read data |
| step_idx | output | 3 | Selected charge step, 0 to 4 |
| delta_out | output | 8 | Signed current offset of the selected step |
| step_pulse | output | 1 | Step index changed |
| req_pulse | output | 1 | Host is asked for a fresh level |
| fail_pulse | output | 1 | Host did not answer before the failure timeout |

## Verification
Two events can land on the same clock edge: a host commit and the expiry of the request timer. The bench commits a level and counts the edges until the request timer would expire. It then commits again so that the commit write reaches the block on exactly that edge. The check passes only if no request pulse appears and the next request arrives a full timeout later, counted from the second commit. The failure expiry is a second collision point: there the step is forced to 4 while the step-change pulse fires. The bench checks both the forced index and the offset of step 4 in the cycle after the failure pulse.

// File: rtl/step_chg_pkg.sv
package step_chg_pkg;
  localparam int NUM_STEPS = 5;
  localparam int NUM_THR   = NUM_STEPS - 1;
  localparam int ADDR_W    = 4;

  localparam logic [ADDR_W-1:0] A_MODE   = 4'h0;
  localparam logic [ADDR_W-1:0] A_REQSEL = 4'h1;
  localparam logic [ADDR_W-1:0] A_FLSEL  = 4'h2;
  localparam logic [ADDR_W-1:0] A_THR0   = 4'h3;
  localparam logic [ADDR_W-1:0] A_DLT0   = 4'h7;
  localparam logic [ADDR_W-1:0] A_LEVEL  = 4'hC;
  localparam logic [ADDR_W-1:0] A_COMMIT = 4'hD;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'hE;

  localparam int MODE_EN_BIT    = 0;
  localparam int MODE_FINAL_BIT = 3;
  localparam int STATUS_LSB     = 3;

  // seconds before asking the host for a new level
  function automatic int req_secs(input logic [1:0] sel);
    return 5 << sel;
  endfunction

  // seconds the host gets to answer a request
  function automatic int fail_secs(input logic [1:0] sel);
    case (sel)
      2'd0:    return 10;
      2'd1:    return 30;
      2'd2:    return 60;
      default: return 120;
    endcase
  endfunction
endpackage

// File: rtl/step_cfg_regs.sv
module step_cfg_regs
  import step_chg_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DW-1:0]        rd_data,
  input  logic [SW-1:0]        step_idx,
  output logic [DW-1:0]        mode,
  output logic [1:0]           req_sel,
  output logic [1:0]           fail_sel,
  output logic [DW-1:0]        thr [NUM_THR],
  output logic [DW-1:0]        dlt [NUM_STEPS],
  output logic [DW-1:0]        level_raw,
  output logic                 commit
);
  logic [DW-1:0] rd_nxt;
  logic [DW-1:0] status;

  assign commit = wr_en && (wr_addr == A_COMMIT) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= '0;
      req_sel   <= '0;
      fail_sel  <= '0;
      level_raw <= '0;
      for (int i = 0; i < NUM_THR; i++) thr[i] <= DW'(100);
    end else if (wr_en) begin
      if (wr_addr == A_MODE)   mode      <= wr_data;
      if (wr_addr == A_REQSEL) req_sel   <= wr_data[1:0];
      if (wr_addr == A_FLSEL)  fail_sel  <= wr_data[1:0];
      if (wr_addr == A_LEVEL)  level_raw <= wr_data;
      for (int i = 0; i < NUM_THR; i++)
        if (wr_addr == ADDR_W'(A_THR0 + i)) thr[i] <= wr_data;
    end
  end

  // offset table: plain write-only-on-strobe memory, no reset
  always_ff @(posedge clk) begin
    if (wr_en)
      for (int i = 0; i < NUM_STEPS; i++)
        if (wr_addr == ADDR_W'(A_DLT0 + i)) dlt[i] <= wr_data;
  end

  always_comb begin
    status = '0;
    status[STATUS_LSB +: SW] = step_idx;
    rd_nxt = '0;
    case (rd_addr)
      A_MODE:   rd_nxt = mode;
      A_REQSEL: rd_nxt = DW'(req_sel);
      A_FLSEL:  rd_nxt = DW'(fail_sel);
      A_LEVEL:  rd_nxt = level_raw;
      A_STATUS: rd_nxt = status;
      default:  rd_nxt = '0;
    endcase
    for (int i = 0; i < NUM_THR; i++)
      if (rd_addr == ADDR_W'(A_THR0 + i)) rd_nxt = thr[i];
    for (int i = 0; i < NUM_STEPS; i++)
      if (rd_addr == ADDR_W'(A_DLT0 + i)) rd_nxt = dlt[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/step_select.sv
module step_select
  import step_chg_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic [DW-1:0] level,
  input  logic [DW-1:0] thr [NUM_THR],
  output logic [SW-1:0] count
);
  logic [NUM_THR-1:0] reached;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
    assign reached[g] = (level >= thr[g]);
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NUM_THR; i++) count = count + SW'(reached[i]);
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = run && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (run && tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/step_charge_ctrl.sv
module step_charge_ctrl
  import step_chg_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_SEC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        step_idx,
  output logic [DATA_W-1:0] delta_out,
  output logic              step_pulse,
  output logic              req_pulse,
  output logic              fail_pulse
);
  localparam int SW       = 3;
  localparam int MAX_TICK = 120 * TICKS_PER_SEC;
  localparam int CW       = $clog2(MAX_TICK + 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(NUM_STEPS - 1);

  logic [DATA_W-1:0] mode, level_raw, cur_level;
  logic [DATA_W-1:0] thr [NUM_THR];
  logic [DATA_W-1:0] dlt [NUM_STEPS];
  logic [1:0]        req_sel, fail_sel;
  logic              commit, en;
  logic [SW-1:0]     step_cnt, step_nxt;
  logic              req_run, fail_run, forced;
  logic              req_done, fail_done, tmr_clr;
  logic [CW-1:0]     req_lim, fail_lim;

  step_cfg_regs #(.DW(DATA_W), .SW(SW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .step_idx(step_idx), .mode(mode),
    .req_sel(req_sel), .fail_sel(fail_sel), .thr(thr), .dlt(dlt),
    .level_raw(level_raw), .commit(commit)
  );

  step_select #(.DW(DATA_W), .SW(SW)) u_sel (
    .level(cur_level), .thr(thr), .count(step_cnt)
  );

  assign en       = mode[MODE_EN_BIT];
  assign req_lim  = CW'(req_secs(req_sel) * TICKS_PER_SEC);
  assign fail_lim = CW'(fail_secs(fail_sel) * TICKS_PER_SEC);
  assign tmr_clr  = !en || commit || req_done || fail_done;

  tick_timer #(.CW(CW)) u_req_tmr (
    .clk(clk), .rst(rst), .tick(tick), .clr(tmr_clr), .run(req_run),
    .limit(req_lim), .done(req_done)
  );

  tick_timer #(.CW(CW)) u_fail_tmr (
    .clk(clk), .rst(rst), .tick(tick), .clr(tmr_clr), .run(fail_run),
    .limit(fail_lim), .done(fail_done)
  );

  always_comb begin
    if (!en)         step_nxt = '0;
    else if (forced) step_nxt = LAST_STEP;
    else             step_nxt = step_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_idx   <= '0;
      delta_out  <= '0;
      step_pulse <= 1'b0;
      req_pulse  <= 1'b0;
      fail_pulse <= 1'b0;
      req_run    <= 1'b0;
      fail_run   <= 1'b0;
      forced     <= 1'b0;
      cur_level  <= '0;
    end else begin
      step_idx   <= step_nxt;
      delta_out  <= en ? dlt[step_nxt] : '0;
      step_pulse <= (step_nxt != step_idx);
      req_pulse  <= 1'b0;
      fail_pulse <= 1'b0;
      if (commit) cur_level <= level_raw >> 1;
      if (!en) begin
        req_run  <= 1'b0;
        fail_run <= 1'b0;
        forced   <= 1'b0;
      end else if (commit) begin
        req_run  <= 1'b1;
        fail_run <= 1'b0;
        forced   <= 1'b0;
      end else if (req_done) begin
        req_run   <= 1'b0;
        fail_run  <= 1'b1;
        req_pulse <= 1'b1;
      end else if (fail_done) begin
        fail_run   <= 1'b0;
        req_run    <= 1'b1;
        fail_pulse <= 1'b1;
        forced     <= mode[MODE_FINAL_BIT];
      end else if (!req_run && !fail_run) begin
        req_run <= 1'b1;
      end
    end
  end

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_pulse && fail_pulse));

  // R4
  step_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    step_pulse |-> (step_idx != $past(step_idx)));

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (step_idx == '0) && (delta_out == '0) && !req_pulse && !fail_pulse);

  // R7
  fail_final_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_pulse && forced && en) |=> (step_idx == LAST_STEP));

  // R8
  commit_wins_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !req_pulse);

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    step_idx <= LAST_STEP);
endmodule

// File: tb/test_step_charge_ctrl.sv
module test_step_charge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 2;

  logic       clk = 1'b0, rst = 1'b1, tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, delta_out;
  logic [2:0] step_idx;
  logic       step_pulse, req_pulse, fail_pulse;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // {level percent, expected step}; thresholds 20,40,60,80
  localparam logic [10:0] VEC [10] = '{
    {8'd0, 3'd0}, {8'd19, 3'd0}, {8'd20, 3'd1}, {8'd39, 3'd1}, {8'd40, 3'd2},
    {8'd59, 3'd2}, {8'd79, 3'd3}, {8'd80, 3'd4}, {8'd100, 3'd4}, {8'd60, 3'd3}
  };
  localparam logic [7:0] THR [4] = '{8'd20, 8'd40, 8'd60, 8'd80};
  localparam int DLT [5] = '{-20, -10, 0, 5, 15};

  step_charge_ctrl #(.DATA_W(8), .TICKS_PER_SEC(TPS)) i_step_charge_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .step_idx(step_idx), .delta_out(delta_out), .step_pulse(step_pulse),
    .req_pulse(req_pulse), .fail_pulse(fail_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called just after a negedge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_level(input int pct);
    wr(4'hC, 8'(pct << 1));
    wr(4'hD, 8'h01);
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  // edges counted from the last write edge until the chosen pulse
  task automatic wait_pulse(input bit fail, input int maxn, output int n);
    n = -1;
    for (int k = 1; k <= maxn; k++) begin
      @(negedge clk);
      if ((fail ? fail_pulse : req_pulse) === 1'b1) begin n = k; break; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int v, n, cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 step", int'(step_idx), 0);
    check("R1 delta", int'(delta_out), 0);
    check("R1 pulses", int'({step_pulse, req_pulse, fail_pulse}), 0);
    rd(4'h3, v); check("R1 threshold", v, 100);
    rd(4'h0, v); check("R1 mode", v, 0);

    for (int i = 0; i < 4; i++) wr(4'(3 + i), THR[i]);
    for (int i = 0; i < 5; i++) wr(4'(7 + i), 8'(DLT[i]));
    wr(4'h0, 8'h09);

    // R2 R3 vector table
    foreach (VEC[i]) begin
      set_level(int'(VEC[i][10:3]));
      @(negedge clk);
      check("R2 step", int'(step_idx), int'(VEC[i][2:0]));
      check("R3 delta", int'($signed(delta_out)), DLT[VEC[i][2:0]]);
    end

    // R4 pulse on change only
    set_level(85);
    @(negedge clk);
    check("R4 pulse on change", int'(step_pulse), 1);
    check("R4 new step", int'(step_idx), 4);
    @(negedge clk);
    check("R4 one cycle", int'(step_pulse), 0);
    set_level(90);
    @(negedge clk);
    check("R4 no pulse same step", int'(step_pulse), 0);

    // R5 R6 R7 with final-step option set
    set_level(30);
    wait_pulse(1'b0, 400, n); check("R5 request 5s", n, 5 * TPS);
    wait_pulse(1'b1, 400, n); check("R6 fail 10s", n, 10 * TPS);
    @(negedge clk);
    check("R7 forced final", int'(step_idx), 4);
    check("R7 forced delta", int'($signed(delta_out)), DLT[4]);
    set_level(30);
    @(negedge clk);
    check("R7 commit clears force", int'(step_idx), 1);

    // R7 hold when option clear
    wr(4'h0, 8'h01);
    set_level(50);
    wait_pulse(1'b0, 400, n);
    wait_pulse(1'b1, 400, n); check("R7 fail seen", n, 10 * TPS);
    @(negedge clk);
    check("R7 step held", int'(step_idx), 2);

    // R5 R6 other selects
    wr(4'h1, 8'h01); wr(4'h2, 8'h03);
    set_level(50);
    wait_pulse(1'b0, 400, n); check("R5 request 10s", n, 10 * TPS);
    wait_pulse(1'b1, 400, n); check("R6 fail 120s", n, 120 * TPS);
    wait_pulse(1'b0, 400, n); check("R6 request restarts", n, 10 * TPS);

    // R8 commit on the expiry edge
    wr(4'h1, 8'h00);
    set_level(50);
    repeat (5 * TPS - 1) @(negedge clk);
    wr(4'hD, 8'h01);
    check("R8 no request", int'(req_pulse), 0);
    wait_pulse(1'b0, 400, n); check("R8 restarted", n, 5 * TPS);

    // R10 status and readback
    set_level(70);
    @(negedge clk);
    rd(4'hE, v); check("R10 status", v, 3 << 3);
    rd(4'h5, v); check("R10 threshold", v, 60);
    rd(4'h8, v); check("R10 offset", int'($signed(8'(v))), DLT[1]);

    // R9 disabled
    wr(4'h0, 8'h00);
    @(negedge clk);
    check("R9 step", int'(step_idx), 0);
    check("R9 delta", int'(delta_out), 0);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      cnt += int'(req_pulse) + int'(fail_pulse);
    end
    check("R9 no timer pulses", cnt, 0);

    finish_run();
  end
endmodule